// File: doc/BRIEF.md
# SDRAM Software-Driven Command Sequencer

This block drives the command pins of an SDR-SDRAM device from software. Software first writes a 3-bit command code into the block's mode register and then performs a write access into the SDRAM window. The block does not store that write as data. It reads the write as a trigger and emits exactly one SDRAM command of the selected kind: NOP, precharge of all banks, auto-refresh, load mode register, or load extended mode register. The address of the trigger write supplies the bank and address pins for the mode-register loads. Code 0 is normal operation.

The device must stay quiet for a power-up pause of 200 µs after reset. The pause is counted in clock cycles from a clock-frequency parameter. Trigger writes that arrive during the pause, or while an earlier command's minimum spacing is still running, are stalled through `bus_ready`. A programmable refresh timer issues periodic auto-refresh commands in normal operation. A refresh that is due takes priority over a trigger write.

Top module: `sdram_cmd_seq`

## Requirements
- R1: A pulse on `mode_wr` loads `mode_wdata` into the mode register. Codes are 0 normal, 1 NOP, 2 precharge-all, 3 mode-register load, 4 auto-refresh, 5 extended mode-register load, and 6/7 reserved.
- R2: A write is accepted on a rising edge where `bus_wr` and `bus_ready` are both high. In codes 1 to 5, an accepted write drives exactly one command in the cycle after that edge. In every other cycle the pins show deselect (`{cs_n,ras_n,cas_n,we_n}` = 1111).
- R3: The NOP command drives pins 0111. The first NOP raises `sd_cke`, and `sd_cke` never falls again until reset.
- R4: After reset, `bus_ready` stays low for CLK_MHZ*PWRUP_US cycles. During that pause `sd_cke` stays 0, every command pin stays at 1, and `sd_ba`/`sd_a` stay at 0. A write held during the pause is accepted on the first edge after the pause.
- R5: The mode-register load drives pins 0000 with `sd_ba`=00 and `sd_a`=`bus_addr[ROW_W-1:0]`. A code-3 write whose bank bits `bus_addr[ROW_W+1:ROW_W]` are not 00 is acknowledged with no command.
- R6: The extended mode-register load drives pins 0000 with `sd_ba` equal to the write's bank bits and `sd_a`=`bus_addr[ROW_W-1:0]`. A code-5 write with bank bits 00 is acknowledged with no command.
- R7: Precharge-all drives pins 0010 with `sd_a[10]`=1 and every other `sd_a` bit 0.
- R8: Auto-refresh drives pins 0001. Eight consecutive code-4 writes give eight separate refresh commands.
- R9: Writes in codes 0, 6 and 7 are acknowledged with no command.
- R10: After a command issued on edge k, the next command can issue no earlier than edge k+T. T is 1 for NOP, T_RP for precharge, T_RC for refresh and T_MRD for either mode load. A held write is accepted exactly at that edge.
- R11: With code 0 and a refresh period P ≥ T_RC written through `refresh_wr`, auto-refresh commands issue every P cycles. No timer refresh issues in any other code or with P = 0.
- R12: A due timer refresh takes priority over a trigger write. `bus_ready` is low on the edge the refresh issues and for T_RC-1 cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 3 | New command code |
| refresh_wr | input | 1 | Refresh period write strobe |
| refresh_wdata | input | REF_W | Refresh period in cycles, 0 disables |
| bus_wr | input | 1 | Write access into the SDRAM window |
| bus_addr | input | ROW_W+2 | Write address, bank bits on top |
| bus_ready | output | 1 | High when a write can be accepted |
| sd_cke | output | 1 | Device clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | ROW_W | Address pins |

## Verification
The command decoder is tried three ways: with directed writes in each code, including mode loads with matching and mismatching bank bits, which separates issued commands from acknowledged-only writes; with seeded random code and address mixes, which catches cross-talk between codes and address fields; and with held back-to-back writes of one code, which measures the exact spacing per command kind. The refresh timer is run alone and then against a continuous stream of writes. The first run checks its period and that it is silent outside normal mode. The second shows that no write is accepted inside a refresh's busy window.

// File: rtl/sdram_cmd_seq.sv
`timescale 1ns/1ps
module sdram_cmd_seq #(
  parameter int CLK_MHZ  = 100,
  parameter int PWRUP_US = 200,
  parameter int ROW_W    = 13,
  parameter int REF_W    = 12,
  parameter int T_RP     = 3,
  parameter int T_RC     = 8,
  parameter int T_MRD    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_wr,
  input  logic [2:0]         mode_wdata,
  input  logic               refresh_wr,
  input  logic [REF_W-1:0]   refresh_wdata,
  input  logic               bus_wr,
  input  logic [ROW_W+1:0]   bus_addr,
  output logic               bus_ready,
  output logic               sd_cke,
  output logic               sd_cs_n,
  output logic               sd_ras_n,
  output logic               sd_cas_n,
  output logic               sd_we_n,
  output logic [1:0]         sd_ba,
  output logic [ROW_W-1:0]   sd_a
);
  localparam int PWRUP_CYC = CLK_MHZ * PWRUP_US;
  localparam int PW_W      = $clog2(PWRUP_CYC + 1);
  localparam int GAP_MAX   = (T_RC > T_RP) ? ((T_RC > T_MRD) ? T_RC : T_MRD)
                                           : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int GAP_W     = $clog2(GAP_MAX + 1);
  localparam int A10       = 10;

  localparam logic [3:0] C_DESEL = 4'b1111;
  localparam logic [3:0] C_NOP   = 4'b0111;
  localparam logic [3:0] C_PRE   = 4'b0010;
  localparam logic [3:0] C_REF   = 4'b0001;
  localparam logic [3:0] C_LMR   = 4'b0000;

  logic [2:0]       mode_q;
  logic [PW_W-1:0]  pwr_cnt;
  logic [GAP_W-1:0] gap;
  logic [REF_W-1:0] period_q, ref_cnt;
  logic             ref_pend;

  wire       pwr_done = (pwr_cnt == '0);
  wire       idle     = pwr_done && (gap == '0);
  wire       ref_fire = ref_pend && (mode_q == 3'd0) && idle;
  wire [1:0] wr_ba    = bus_addr[ROW_W+1:ROW_W];

  assign bus_ready = idle && !ref_fire;
  wire accept = bus_wr && bus_ready;

  logic [3:0]       n_code;
  logic [GAP_W-1:0] n_hold;
  logic [1:0]       n_ba;
  logic [ROW_W-1:0] n_a;

  always_comb begin
    n_code = C_DESEL;
    n_hold = '0;
    n_ba   = 2'b00;
    n_a    = '0;
    if (ref_fire) begin
      n_code = C_REF;
      n_hold = GAP_W'(T_RC - 1);
    end else if (accept) begin
      case (mode_q)
        3'd1: n_code = C_NOP;
        3'd2: begin
          n_code   = C_PRE;
          n_a[A10] = 1'b1;
          n_hold   = GAP_W'(T_RP - 1);
        end
        3'd3: if (wr_ba == 2'b00) begin
          n_code = C_LMR;
          n_a    = bus_addr[ROW_W-1:0];
          n_hold = GAP_W'(T_MRD - 1);
        end
        3'd4: begin
          n_code = C_REF;
          n_hold = GAP_W'(T_RC - 1);
        end
        3'd5: if (wr_ba != 2'b00) begin
          n_code = C_LMR;
          n_ba   = wr_ba;
          n_a    = bus_addr[ROW_W-1:0];
          n_hold = GAP_W'(T_MRD - 1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 3'd0;
      pwr_cnt <= PW_W'(PWRUP_CYC);
      gap     <= '0;
      sd_cke  <= 1'b0;
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= C_DESEL;
      sd_ba   <= 2'b00;
      sd_a    <= '0;
    end else begin
      if (mode_wr) mode_q <= mode_wdata;
      if (!pwr_done) pwr_cnt <= pwr_cnt - 1'b1;
      if (n_code != C_DESEL) gap <= n_hold;
      else if (gap != '0)    gap <= gap - 1'b1;
      if (n_code == C_NOP) sd_cke <= 1'b1;
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= n_code;
      sd_ba <= n_ba;
      sd_a  <= n_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      ref_cnt  <= '0;
      ref_pend <= 1'b0;
    end else if (refresh_wr) begin
      period_q <= refresh_wdata;
      ref_cnt  <= refresh_wdata - 1'b1;
      ref_pend <= 1'b0;
    end else begin
      if (ref_fire) ref_pend <= 1'b0;
      if (mode_q != 3'd0 || period_q == '0) begin
        ref_cnt <= period_q - 1'b1;
      end else if (ref_cnt == '0) begin
        ref_pend <= 1'b1;
        ref_cnt  <= period_q - 1'b1;
      end else begin
        ref_cnt <= ref_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_seq_chk.sv
`timescale 1ns/1ps
module sdram_cmd_seq_chk #(
  parameter int T_RP  = 3,
  parameter int T_RC  = 8,
  parameter int T_MRD = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic [1:0] ba,
  input logic       bus_wr,
  input logic       bus_ready,
  input logic       pwr_done,
  input logic       ref_fire,
  input logic [2:0] mode_q
);
  logic [7:0] since, need;
  wire [2:0] pins = {ras_n, cas_n, we_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= 8'd0;
      need  <= 8'd0;
    end else if (!cs_n) begin
      since <= 8'd1;
      case (pins)
        3'b010:  need <= 8'(T_RP);
        3'b001:  need <= 8'(T_RC);
        3'b000:  need <= 8'(T_MRD);
        default: need <= 8'd1;
      endcase
    end else if (since != 8'hff) begin
      since <= since + 8'd1;
    end
  end

  a_r3_cke_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  a_r4_quiet_pause: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_done |-> (cs_n && !cke));

  a_r2_cmd_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> ($past(bus_wr && bus_ready) || $past(ref_fire)));

  a_r5_mrs_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && pins == 3'b000 && $past(mode_q) == 3'd3) |-> (ba == 2'b00));

  a_r6_emrs_bank_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && pins == 3'b000 && $past(mode_q) == 3'd5) |-> (ba != 2'b00));

  a_r10_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (since >= need));

  a_r12_refresh_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fire |=> (!cs_n && pins == 3'b001));
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(.T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(sd_cke), .cs_n(sd_cs_n), .ras_n(sd_ras_n),
  .cas_n(sd_cas_n), .we_n(sd_we_n), .ba(sd_ba), .bus_wr(bus_wr),
  .bus_ready(bus_ready), .pwr_done(pwr_done), .ref_fire(ref_fire), .mode_q(mode_q)
);

// File: tb/sdram_cmd_seq_tb.sv
`timescale 1ns/1ps
module sdram_cmd_seq_tb;
  localparam int ROW_W = 13;
  localparam int REF_W = 12;
  localparam int T_RP = 3, T_RC = 8, T_MRD = 2;
  localparam int PWRUP = 100 * 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_wr = 1'b0, refresh_wr = 1'b0, bus_wr = 1'b0;
  logic [2:0] mode_wdata = '0;
  logic [REF_W-1:0] refresh_wdata = '0;
  logic [ROW_W+1:0] bus_addr = '0;
  logic bus_ready, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_ba;
  logic [ROW_W-1:0] sd_a;

  sdram_cmd_seq #(.CLK_MHZ(100), .PWRUP_US(2), .ROW_W(ROW_W), .REF_W(REF_W),
                  .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .refresh_wr(refresh_wr), .refresh_wdata(refresh_wdata), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_ready(bus_ready), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a));

  always #5 clk = ~clk;

  int cyc = 0, total = 0, bad = 0;
  int ncmd = 0, nref = 0, last_cyc = -1, last_ref = -1000, ref_gap = -1, ready_cyc = -1;
  logic [2:0] last_code;
  logic [1:0] last_ba;
  logic [ROW_W-1:0] last_a;
  bit in_pause = 1'b1, early_bad = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (in_pause) begin
      if (sd_cke || !sd_cs_n || !sd_ras_n || !sd_cas_n || !sd_we_n || sd_ba != 0 || sd_a != 0)
        early_bad = 1'b1;
      if (bus_ready) begin in_pause = 1'b0; ready_cyc = cyc; end
    end
    if (!sd_cs_n) begin
      ncmd++;
      last_code = {sd_ras_n, sd_cas_n, sd_we_n};
      last_ba = sd_ba; last_a = sd_a; last_cyc = cyc;
      if (last_code == 3'b001) begin
        nref++;
        ref_gap = cyc - last_ref;
        last_ref = cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_fires(input logic [2:0] m, input logic [1:0] b);
    case (m)
      3'd1, 3'd2, 3'd4: return 1'b1;
      3'd3: return b == 2'b00;
      3'd5: return b != 2'b00;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] exp_code(input logic [2:0] m);
    case (m)
      3'd1: return 3'b111;
      3'd2: return 3'b010;
      3'd4: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [ROW_W-1:0] exp_a(input logic [2:0] m, input logic [ROW_W-1:0] low);
    if (m == 3'd2) return ROW_W'(1 << 10);
    if (m == 3'd3 || m == 3'd5) return low;
    return '0;
  endfunction

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk); mode_wr = 1'b1; mode_wdata = m;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic set_period(input int p);
    @(negedge clk); refresh_wr = 1'b1; refresh_wdata = REF_W'(p);
    @(negedge clk); refresh_wr = 1'b0;
  endtask

  task automatic access(input logic [ROW_W+1:0] addr, output int acc);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = addr;
    while (!bus_ready) @(negedge clk);
    @(posedge clk);
    #1 bus_wr = 1'b0;
    acc = cyc;
  endtask

  task automatic cmd_access(input logic [2:0] m, input logic [1:0] b, input logic [ROW_W-1:0] low,
                            input string req, output int acc);
    int n0;
    bit f;
    n0 = ncmd;
    access({b, low}, acc);
    @(negedge clk); #1;
    f = exp_fires(m, b);
    chk(ncmd == n0 + int'(f), req, "command count", ncmd - n0, int'(f));
    if (f) begin
      chk(last_code == exp_code(m), req, "pins ras/cas/we", int'(last_code), int'(exp_code(m)));
      chk(last_cyc == acc, req, "issue edge", last_cyc, acc);
      chk(last_ba == ((m == 3'd5) ? b : 2'b00), req, "bank pins", int'(last_ba), (m == 3'd5) ? int'(b) : 0);
      chk(last_a == exp_a(m, low), req, "address pins", int'(last_a), int'(exp_a(m, low)));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0, a0, a1, n0, viol;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(sd_cke == 0 && sd_cs_n == 1 && bus_ready == 0, "R4", "reset state", int'({sd_cke, sd_cs_n, bus_ready}), 2);
    rst_n = 1'b1; c0 = cyc;

    // R1 R3 R4: NOP held through the pause
    set_mode(3'd1);
    cmd_access(3'd1, 2'b00, '0, "R3", a0);
    chk(ready_cyc - c0 == PWRUP, "R4", "pause length", ready_cyc - c0, PWRUP);
    chk(a0 == c0 + PWRUP + 1, "R4", "first accept edge", a0, c0 + PWRUP + 1);
    chk(!early_bad, "R4", "pins moved in pause", int'(early_bad), 0);
    chk(sd_cke == 1'b1, "R3", "cke after NOP", int'(sd_cke), 1);

    // R7 R10 precharge spacing
    set_mode(3'd2);
    cmd_access(3'd2, 2'b11, 13'h1fff, "R7", a0);
    cmd_access(3'd2, 2'b00, 13'h0, "R7", a1);
    chk(a1 - a0 == T_RP, "R10", "precharge spacing", a1 - a0, T_RP);

    // R8 R10 eight refreshes
    set_mode(3'd4);
    n0 = nref;
    cmd_access(3'd4, 2'b01, 13'h55, "R8", a0);
    for (int i = 0; i < 7; i++) begin
      cmd_access(3'd4, 2'b00, 13'h0, "R8", a1);
      chk(a1 - a0 == T_RC, "R10", "refresh spacing", a1 - a0, T_RC);
      a0 = a1;
    end
    chk(nref - n0 == 8, "R8", "refresh count", nref - n0, 8);

    // R5 R6 mode loads and their bank-bit corners
    set_mode(3'd3);
    cmd_access(3'd3, 2'b00, 13'h032, "R5", a0);
    cmd_access(3'd3, 2'b00, 13'h1a5, "R5", a1);
    chk(a1 - a0 == T_MRD, "R10", "mode load spacing", a1 - a0, T_MRD);
    cmd_access(3'd3, 2'b10, 13'h032, "R5", a0);
    set_mode(3'd5);
    cmd_access(3'd5, 2'b01, 13'h003, "R6", a0);
    cmd_access(3'd5, 2'b11, 13'h1f0, "R6", a0);
    cmd_access(3'd5, 2'b00, 13'h003, "R6", a0);

    // R9 acknowledged-only codes
    set_mode(3'd6); cmd_access(3'd6, 2'b01, 13'h7, "R9", a0);
    set_mode(3'd7); cmd_access(3'd7, 2'b10, 13'h8, "R9", a0);
    set_mode(3'd0); cmd_access(3'd0, 2'b11, 13'h9, "R9", a0);

    // R2 R1 random mix
    for (int i = 0; i < 40; i++) begin
      logic [2:0] m;
      logic [1:0] b;
      logic [ROW_W-1:0] low;
      m = 3'($urandom_range(7, 0));
      b = 2'($urandom);
      low = ROW_W'($urandom);
      set_mode(m);
      cmd_access(m, b, low, "R2", a0);
    end

    // R11 refresh timer
    set_mode(3'd0);
    set_period(20);
    repeat (30) @(negedge clk);
    n0 = nref;
    repeat (100) @(negedge clk);
    chk(nref - n0 >= 4 && nref - n0 <= 6, "R11", "timer refresh count", nref - n0, 5);
    chk(ref_gap == 20, "R11", "timer period", ref_gap, 20);
    set_mode(3'd1);
    repeat (5) @(negedge clk);
    n0 = nref;
    repeat (100) @(negedge clk);
    chk(nref == n0, "R11", "refresh outside normal mode", nref - n0, 0);
    set_period(0);
    set_mode(3'd0);
    repeat (5) @(negedge clk);
    n0 = nref;
    repeat (100) @(negedge clk);
    chk(nref == n0, "R11", "refresh with zero period", nref - n0, 0);

    // R12 refresh against a stream of writes
    set_period(20);
    n0 = nref; viol = 0;
    for (int i = 0; i < 60; i++) begin
      access({2'($urandom), ROW_W'($urandom)}, a0);
      @(negedge clk); #1;
      if (a0 - last_ref < T_RC) viol++;
    end
    chk(viol == 0, "R12", "writes inside refresh window", viol, 0);
    chk(nref - n0 >= 5, "R12", "refreshes during stream", nref - n0, 6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule